// File: doc/BRIEF.md
# Parallel SAR Converter Read Controller

This block runs a 16-bit successive-approximation converter that has a parallel output port. The block and the converter share no clock: the block works on the host clock. A one-bit trigger asks for a sample. The controller then drives the converter's chip-select, read/convert and byte-swap pins and waits for the converter's busy line to fall and rise again. It then reads the result off the data pins and offers it downstream as a signed two's-complement word on a valid/ready interface.

Each timing limit of the converter is a nanosecond parameter. The block turns it into a whole number of host clock cycles, rounding to the safe side: minimums round up and deadlines round down. The limits covered are start pulse width, release deadline, select setup, acquisition, start spacing, bus access, byte delay, bus release and a busy timeout.

Two parameters pick the variant. One selects a full 16-bit read or two byte reads over the upper eight data pins. The other selects whether the conversion starts on read/convert, with chip-select held low, or on chip-select. Back-pressure rules: a sample stays on the output, unchanged, until it is accepted. The output can hold only one sample, so no new conversion starts while one is waiting.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is low and right after it, read/convert is high, byte select is low, valid is low and the error flag is low. Chip-select is high in the select-started variant and low in the read/convert-started variant.
- R2: The start pulse is the span in which chip-select and read/convert are both low. It lasts at least ceil(40 ns / clock period) cycles, which is 5 cycles at 8 ns.
- R3: The start pulse ends within floor(1000 ns / clock period) cycles, which is 125 cycles at 8 ns.
- R4: In the select-started variant, read/convert falls at least ceil(10 ns / period) cycles before chip-select falls. That is 2 cycles at 8 ns.
- R5: Two starts are at least ceil(4000 ns / period) cycles apart (500). A start also comes at least ceil(1500 ns / period) cycles (188) after the converter's busy line rose.
- R6: Completion is taken only after busy has been seen low and then high again. Whenever busy rises, read/convert or chip-select is high.
- R7: In the 16-bit variant, the whole data bus is captured after the output has been enabled for ceil(60 ns / period) cycles (8). The word is presented as a signed two's-complement value, with bit 15 as the sign.
- R8: In the byte variant, the high byte is read on data pins 15:8 with byte select low. Byte select is then raised, and after ceil(60 ns / period) cycles the low byte is read on the same pins. The result is {high, low}.
- R9: While valid is high and ready is low, valid stays high and the data does not change. Valid falls in the cycle after a cycle in which valid and ready are both high.
- R10: A trigger is ignored, and starts no conversion, if it comes while a sample is pending, while a conversion or read is under way, or before the spacing and acquisition windows have elapsed.
- R11: If busy has not completed its low-then-high sequence within ceil(3000 ns / period) cycles after the start pulse ends, the error flag rises, no sample is delivered and the block returns to idle. The next accepted trigger clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Conversion request (level, taken when the block can start) |
| busy_i | input | 1 | Converter busy line, low while converting (asynchronous) |
| data_i | input | 16 | Converter data pins |
| cs_n_o | output | 1 | Converter chip-select, active low |
| rc_o | output | 1 | Converter read/convert, low to convert |
| byte_o | output | 1 | Converter byte swap, high puts the low byte on pins 15:8 |
| smp_valid_o | output | 1 | Sample valid |
| smp_ready_i | input | 1 | Sample accepted by downstream |
| smp_data_o | output | 16 | Signed sample |
| err_o | output | 1 | Busy timeout flag |

## Verification
The case hardest to reach from the ports is a read made too early. A real bus holds its old value, so data sampled before the access or byte-delay time looks correct. The behavioural converter in the bench therefore drives a marker word until the enable or the byte select has been steady for the required cycles, so any early capture shows up as a wrong word. The timeout path needs a converter that never answers: a stall input makes the model ignore a start, so busy never moves and only the controller's own timeout can end the wait.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_START,
    ST_WAIT,
    ST_RD_HI,
    ST_RD_LO,
    ST_REL
  } rd_state_t;

  // minimum window: round up, never below one cycle
  function automatic int unsigned cyc_ceil(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  // deadline: round down, never below one cycle
  function automatic int unsigned cyc_floor(int unsigned ns, int unsigned per);
    int unsigned c;
    c = ns / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) pipe[0] <= 1'b1;
          else        pipe[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) pipe[g] <= 1'b1;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load_i)         cnt <= val_i;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign done_o = (cnt == '0);
endmodule

// File: rtl/adc_rd_hold.sv
module adc_rd_hold #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R9: a waiting sample neither vanishes nor changes
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(data_o));

  // R10: the controller never captures over a pending sample
  a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !valid_o);
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned CLK_NS       = 8,
  parameter int unsigned T_PULSE_NS   = 40,
  parameter int unsigned T_RELEASE_NS = 1000,
  parameter int unsigned T_SETUP_NS   = 10,
  parameter int unsigned T_ACQ_NS     = 1500,
  parameter int unsigned T_SPACE_NS   = 4000,
  parameter int unsigned T_ACCESS_NS  = 60,
  parameter int unsigned T_BYTE_NS    = 60,
  parameter int unsigned T_RELINQ_NS  = 50,
  parameter int unsigned T_TIMEOUT_NS = 3000,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned BYTE_READ    = 0,
  parameter int unsigned START_BY_CS  = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_i,
  input  logic               busy_i,
  input  logic [15:0]        data_i,
  output logic               cs_n_o,
  output logic               rc_o,
  output logic               byte_o,
  output logic               smp_valid_o,
  input  logic               smp_ready_i,
  output logic signed [15:0] smp_data_o,
  output logic               err_o
);
  localparam int unsigned C_PULSE   = cyc_ceil(T_PULSE_NS, CLK_NS);
  localparam int unsigned C_RELEASE = cyc_floor(T_RELEASE_NS, CLK_NS);
  localparam int unsigned C_SETUP   = cyc_ceil(T_SETUP_NS, CLK_NS);
  localparam int unsigned C_ACQ     = cyc_ceil(T_ACQ_NS, CLK_NS);
  localparam int unsigned C_SPACE   = cyc_ceil(T_SPACE_NS, CLK_NS);
  localparam int unsigned C_ACCESS  = cyc_ceil(T_ACCESS_NS, CLK_NS);
  localparam int unsigned C_BYTE    = cyc_ceil(T_BYTE_NS, CLK_NS);
  localparam int unsigned C_RELINQ  = cyc_ceil(T_RELINQ_NS, CLK_NS);
  localparam int unsigned C_TIMEOUT = cyc_ceil(T_TIMEOUT_NS, CLK_NS);
  localparam int unsigned C_MAX     = umax(umax(umax(C_SPACE, C_TIMEOUT), umax(C_ACQ, C_RELEASE)),
                                           umax(umax(C_PULSE, C_SETUP),
                                                umax(C_ACCESS, umax(C_BYTE, C_RELINQ))));
  localparam int unsigned CW        = $clog2(C_MAX + 1);

  rd_state_t     state, state_d;
  logic          busy_s, seen_lo;
  logic          step_ld, sp_ld, acq_ld, cap_ld, hi_ld, err_set, err_clr;
  logic [CW-1:0] step_val;
  logic          step_done, sp_done, acq_done;
  logic [7:0]    hi_q;
  logic [15:0]   cap_word, hold_data;

  adc_rd_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
    .clk(clk), .rst_n(rst_n), .d_i(busy_i), .q_o(busy_s)
  );

  adc_rd_timer #(.CW(CW)) u_step (
    .clk(clk), .rst_n(rst_n), .load_i(step_ld), .val_i(step_val), .done_o(step_done)
  );

  adc_rd_timer #(.CW(CW)) u_space (
    .clk(clk), .rst_n(rst_n), .load_i(sp_ld), .val_i(CW'(C_SPACE - 1)), .done_o(sp_done)
  );

  adc_rd_timer #(.CW(CW)) u_acq (
    .clk(clk), .rst_n(rst_n), .load_i(acq_ld), .val_i(CW'(C_ACQ - 1)), .done_o(acq_done)
  );

  generate
    if (BYTE_READ != 0) begin : g_byte
      assign cap_word = {hi_q, data_i[15:8]};
    end else begin : g_word
      assign cap_word = data_i;
    end
  endgenerate

  adc_rd_hold #(.W(16)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(cap_ld), .data_i(cap_word),
    .ready_i(smp_ready_i), .valid_o(smp_valid_o), .data_o(hold_data)
  );

  assign smp_data_o = signed'(hold_data);

  always_comb begin
    state_d  = state;
    step_ld  = 1'b0;
    step_val = '0;
    sp_ld    = 1'b0;
    acq_ld   = 1'b0;
    cap_ld   = 1'b0;
    hi_ld    = 1'b0;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (trig_i && !smp_valid_o && sp_done && acq_done) begin
          err_clr = 1'b1;
          step_ld = 1'b1;
          if (START_BY_CS != 0) begin
            state_d  = ST_SETUP;
            step_val = CW'(C_SETUP - 1);
          end else begin
            state_d  = ST_START;
            step_val = CW'(C_PULSE - 1);
            sp_ld    = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        if (step_done) begin
          state_d  = ST_START;
          step_ld  = 1'b1;
          step_val = CW'(C_PULSE - 1);
          sp_ld    = 1'b1;
        end
      end
      ST_START: begin
        if (step_done) begin
          state_d  = ST_WAIT;
          step_ld  = 1'b1;
          step_val = CW'(C_TIMEOUT - 1);
        end
      end
      ST_WAIT: begin
        if (seen_lo && busy_s) begin
          state_d  = ST_RD_HI;
          acq_ld   = 1'b1;
          step_ld  = 1'b1;
          step_val = CW'(C_ACCESS - 1);
        end else if (step_done) begin
          state_d  = ST_IDLE;
          err_set  = 1'b1;
        end
      end
      ST_RD_HI: begin
        if (step_done) begin
          step_ld = 1'b1;
          if (BYTE_READ != 0) begin
            state_d  = ST_RD_LO;
            hi_ld    = 1'b1;
            step_val = CW'(C_BYTE - 1);
          end else begin
            state_d  = ST_REL;
            cap_ld   = 1'b1;
            step_val = CW'(C_RELINQ - 1);
          end
        end
      end
      ST_RD_LO: begin
        if (step_done) begin
          state_d  = ST_REL;
          cap_ld   = 1'b1;
          step_ld  = 1'b1;
          step_val = CW'(C_RELINQ - 1);
        end
      end
      ST_REL: begin
        if (step_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      seen_lo <= 1'b0;
      hi_q    <= '0;
      err_o   <= 1'b0;
    end else begin
      state <= state_d;
      if (state != ST_WAIT) seen_lo <= 1'b0;
      else if (!busy_s)     seen_lo <= 1'b1;
      if (hi_ld) hi_q <= data_i[15:8];
      if (err_set)      err_o <= 1'b1;
      else if (err_clr) err_o <= 1'b0;
    end
  end

  assign rc_o   = !(state == ST_SETUP || state == ST_START);
  assign byte_o = (state == ST_RD_LO);

  generate
    if (START_BY_CS != 0) begin : g_cs_start
      assign cs_n_o = !(state == ST_START || state == ST_RD_HI || state == ST_RD_LO);
    end else begin : g_rc_start
      assign cs_n_o = 1'b0;
    end
  endgenerate

  // run length of the start pulse, used only by the checks below
  logic [CW-1:0] lo_run;
  always_ff @(posedge clk) begin
    if (!rst_n)               lo_run <= '0;
    else if (!rc_o && !cs_n_o) lo_run <= lo_run + 1'b1;
    else                      lo_run <= '0;
  end

  // R2: start pulse is never shorter than the minimum width
  a_r2_pulse_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rc_o | cs_n_o) |-> lo_run >= CW'(C_PULSE));

  // R3: start pulse ends before the release deadline
  a_r3_release_deadline: assert property (@(posedge clk) disable iff (!rst_n)
    (!rc_o && !cs_n_o) |-> lo_run < CW'(C_RELEASE));

  // R6: busy never rises while both start lines are low
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_i) |-> (rc_o || cs_n_o));

  // R8: byte swap only raised while the output is enabled
  a_r8_byte_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    byte_o |-> (!cs_n_o && rc_o));
endmodule

// File: tb/adc_conv_model.sv
module adc_conv_model #(
  parameter int CONV_CYC = 250,
  parameter int ACC_CYC  = 8,
  parameter int BYTE_CYC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        rc,
  input  logic        byte_sel,
  input  logic        stall,
  input  logic [15:0] next_val,
  output logic        busy,
  output logic [15:0] bus,
  output int          n_start,
  output int          min_pulse,
  output int          max_pulse,
  output int          min_setup,
  output int          min_gap,
  output int          min_acq,
  output int          n_viol
);
  logic        lo, en, lo_q, en_q, byte_q, rc_q, cs_q, conv;
  logic [15:0] latch;
  int cyc, cnt, lo_run, en_cnt, bs_cnt, last_start, last_rise, rc_fall, en_cur, bs_cur;

  assign lo = !cs_n && !rc;
  assign en = !cs_n && rc;

  always_comb begin
    en_cur = en ? (en_q ? en_cnt + 1 : 1) : 0;
    bs_cur = (byte_sel == byte_q) ? bs_cnt + 1 : 1;
    if (en_cur >= ACC_CYC && bs_cur >= BYTE_CYC)
      bus = byte_sel ? {latch[7:0], latch[15:8]} : latch;
    else
      bus = 16'hDEAD;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b1; conv <= 1'b0; latch <= 16'h0000; cyc <= 0; cnt <= 0;
      lo_q <= 1'b0; en_q <= 1'b0; byte_q <= 1'b0; rc_q <= 1'b1; cs_q <= 1'b1;
      lo_run <= 0; en_cnt <= 0; bs_cnt <= 0; last_start <= 0; last_rise <= -1; rc_fall <= 0;
      n_start <= 0; min_pulse <= 1000000; max_pulse <= 0; min_setup <= 1000000;
      min_gap <= 1000000; min_acq <= 1000000; n_viol <= 0;
    end else begin
      cyc    <= cyc + 1;
      lo_q   <= lo;
      en_q   <= en;
      byte_q <= byte_sel;
      rc_q   <= rc;
      cs_q   <= cs_n;
      en_cnt <= en ? (en_q ? en_cnt + 1 : 1) : 0;
      bs_cnt <= (byte_sel == byte_q) ? bs_cnt + 1 : 1;
      lo_run <= lo ? lo_run + 1 : 0;
      if (!lo && lo_q) begin
        if (lo_run < min_pulse) min_pulse <= lo_run;
        if (lo_run > max_pulse) max_pulse <= lo_run;
      end
      if (!rc && rc_q) rc_fall <= cyc;
      if (!cs_n && cs_q && !rc && (cyc - rc_fall < min_setup)) min_setup <= cyc - rc_fall;
      if (lo && !lo_q && !conv && !stall) begin
        n_start <= n_start + 1;
        if (n_start > 0 && (cyc - last_start) < min_gap) min_gap <= cyc - last_start;
        if (last_rise >= 0 && (cyc - last_rise) < min_acq) min_acq <= cyc - last_rise;
        last_start <= cyc;
        conv <= 1'b1;
        busy <= 1'b0;
        cnt  <= CONV_CYC;
      end else if (conv) begin
        if (cnt <= 1) begin
          conv      <= 1'b0;
          busy      <= 1'b1;
          latch     <= next_val;
          last_rise <= cyc;
          if (lo) n_viol <= n_viol + 1;
        end else begin
          cnt <= cnt - 1;
        end
      end
    end
  end
endmodule

// File: tb/test_adc_rd_ctrl.sv
module test_adc_rd_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [1:0] trig, busy, cs_n, rc, bsel, vld, rdy, err, stall;
  logic [15:0] bus [2];
  logic signed [15:0] dat [2];
  logic [15:0] nv [2];
  int n_start [2], min_pulse [2], max_pulse [2], min_setup [2];
  int min_gap [2], min_acq [2], n_viol [2];
  int errs = 0, checks = 0;
  bit done = 1'b0;

  // value in [31:16], back-pressure cycles in [15:0]
  localparam logic [31:0] VEC [6] = '{
    32'h7FFF_0000, 32'h8000_0003, 32'h0000_0001,
    32'hFFFF_0005, 32'h1234_0000, 32'hA5C3_0002
  };

  adc_rd_ctrl i_adc_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_i(trig[0]), .busy_i(busy[0]), .data_i(bus[0]),
    .cs_n_o(cs_n[0]), .rc_o(rc[0]), .byte_o(bsel[0]), .smp_valid_o(vld[0]),
    .smp_ready_i(rdy[0]), .smp_data_o(dat[0]), .err_o(err[0])
  );

  adc_rd_ctrl #(.BYTE_READ(1), .START_BY_CS(1)) i_adc_rd_ctrl_b (
    .clk(clk), .rst_n(rst_n), .trig_i(trig[1]), .busy_i(busy[1]), .data_i(bus[1]),
    .cs_n_o(cs_n[1]), .rc_o(rc[1]), .byte_o(bsel[1]), .smp_valid_o(vld[1]),
    .smp_ready_i(rdy[1]), .smp_data_o(dat[1]), .err_o(err[1])
  );

  adc_conv_model m0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n[0]), .rc(rc[0]), .byte_sel(bsel[0]), .stall(stall[0]),
    .next_val(nv[0]), .busy(busy[0]), .bus(bus[0]), .n_start(n_start[0]),
    .min_pulse(min_pulse[0]), .max_pulse(max_pulse[0]), .min_setup(min_setup[0]),
    .min_gap(min_gap[0]), .min_acq(min_acq[0]), .n_viol(n_viol[0])
  );

  adc_conv_model m1 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n[1]), .rc(rc[1]), .byte_sel(bsel[1]), .stall(stall[1]),
    .next_val(nv[1]), .busy(busy[1]), .bus(bus[1]), .n_start(n_start[1]),
    .min_pulse(min_pulse[1]), .max_pulse(max_pulse[1]), .min_setup(min_setup[1]),
    .min_gap(min_gap[1]), .min_acq(min_acq[1]), .n_viol(n_viol[1])
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_vec(input int u, input logic [15:0] v, input int dly);
    int s0, n;
    string rq;
    rq = (u == 0) ? "R7" : "R8";
    nv[u] = v;
    s0 = n_start[u];
    trig[u] = 1'b1;
    n = 0;
    while (n_start[u] == s0 && n < 2000) begin @(negedge clk); n++; end
    trig[u] = 1'b0;
    chk(n_start[u] == s0 + 1, "R5", "conversion started once windows allowed", n_start[u], s0 + 1);
    n = 0;
    while (!vld[u] && n < 3000) begin @(negedge clk); n++; end
    chk(vld[u] == 1'b1, rq, "sample delivered", int'(vld[u]), 1);
    chk(dat[u] == $signed(v), rq, "captured word", int'(dat[u]), int'($signed(v)));
    chk((dat[u] < 0) == v[15], rq, "sign from bit 15", int'(dat[u] < 0), int'(v[15]));
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk(vld[u] && dat[u] == $signed(v), "R9", "held under back-pressure", int'(dat[u]), int'($signed(v)));
    end
    rdy[u] = 1'b1;
    @(negedge clk);
    rdy[u] = 1'b0;
    chk(vld[u] == 1'b0, "R9", "valid drops after handshake", int'(vld[u]), 0);
  endtask

  task automatic run_timeout(input int u);
    int s0;
    wait_cyc(600);
    stall[u] = 1'b1;
    s0 = n_start[u];
    trig[u] = 1'b1;
    @(negedge clk);
    trig[u] = 1'b0;
    wait_cyc(20);
    chk(err[u] == 1'b0, "R11", "no error before timeout", int'(err[u]), 0);
    wait_cyc(420);
    chk(err[u] == 1'b1, "R11", "error after busy timeout", int'(err[u]), 1);
    chk(vld[u] == 1'b0, "R11", "no sample after timeout", int'(vld[u]), 0);
    chk(n_start[u] == s0, "R11", "stalled converter not started", n_start[u], s0);
    stall[u] = 1'b0;
    run_vec(u, 16'h0F0F, 0);
    chk(err[u] == 1'b0, "R11", "error cleared by accepted trigger", int'(err[u]), 0);
  endtask

  task automatic run_refuse(input int u);
    int s0, n;
    nv[u] = 16'h4321;
    s0 = n_start[u];
    trig[u] = 1'b1;
    n = 0;
    while (n_start[u] == s0 && n < 2000) begin @(negedge clk); n++; end
    trig[u] = 1'b0;
    n = 0;
    while (!vld[u] && n < 3000) begin @(negedge clk); n++; end
    wait_cyc(600);
    s0 = n_start[u];
    trig[u] = 1'b1;
    wait_cyc(600);
    trig[u] = 1'b0;
    wait_cyc(2);
    chk(n_start[u] == s0, "R10", "trigger ignored while sample pending", n_start[u], s0);
    chk(vld[u] && dat[u] == 16'sh4321, "R10", "pending sample untouched", int'(dat[u]), 16'h4321);
    rdy[u] = 1'b1;
    @(negedge clk);
    rdy[u] = 1'b0;
    // start spacing: trigger soon after a short conversion is refused
    run_vec(u, 16'h5A5A, 0);
    s0 = n_start[u];
    trig[u] = 1'b1;
    @(negedge clk);
    trig[u] = 1'b0;
    wait_cyc(20);
    chk(n_start[u] == s0, "R10", "trigger inside spacing window ignored", n_start[u], s0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    trig = '0; rdy = '0; stall = '0;
    nv[0] = '0; nv[1] = '0;
    wait_cyc(5);
    for (int u = 0; u < 2; u++) begin
      chk(rc[u] == 1'b1, "R1", "read/convert high in reset", int'(rc[u]), 1);
      chk(cs_n[u] == (u == 1), "R1", "chip-select level in reset", int'(cs_n[u]), int'(u == 1));
      chk(bsel[u] == 1'b0 && vld[u] == 1'b0 && err[u] == 1'b0, "R1", "byte/valid/err low in reset",
          int'({bsel[u], vld[u], err[u]}), 0);
    end
    rst_n = 1'b1;
    wait_cyc(3);
    for (int u = 0; u < 2; u++) begin
      chk(rc[u] == 1'b1 && vld[u] == 1'b0, "R1", "idle after reset", int'({rc[u], vld[u]}), 2);
    end

    for (int u = 0; u < 2; u++) begin
      for (int i = 0; i < 6; i++) begin
        run_vec(u, VEC[i][31:16], int'(VEC[i][15:0]));
      end
    end

    run_refuse(0);
    run_refuse(1);
    run_timeout(0);
    run_timeout(1);
    wait_cyc(10);

    for (int u = 0; u < 2; u++) begin
      chk(min_pulse[u] >= 5, "R2", "shortest start pulse", min_pulse[u], 5);
      chk(max_pulse[u] <= 125 && max_pulse[u] > 0, "R3", "longest start pulse", max_pulse[u], 125);
      chk(min_gap[u] >= 500, "R5", "shortest start spacing", min_gap[u], 500);
      chk(min_acq[u] >= 188, "R5", "shortest acquisition", min_acq[u], 188);
      chk(n_viol[u] == 0, "R6", "busy rose with start lines low", n_viol[u], 0);
    end
    chk(min_setup[1] >= 2, "R4", "read/convert to select setup", min_setup[1], 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule